// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the address register of a pipelined burst memory and steps the low-order bits through one four-word burst. A start strobe loads the whole external address and clears a beat counter. Each qualified advance then moves the counter by one. The upper address bits stay fixed for the whole burst.

The output address is formed from the stored start address and the beat counter. An order-select pin chooses one of two count orders. In interleaved order, the start low bits are XORed with the counter. In linear order, the counter is added to the start low bits modulo four. The block has no streaming data path, so every pin is a plain control or address signal.

An advance takes effect only when three conditions hold: the active-low advance pin is low, and both active-low address strobes are high. The strobes arrive here already decoded; this block only uses them as a gate.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, addr_o is all zeros.
- R2: A rising clock edge with load_i high captures addr_i into the address register and clears the beat count. From the next cycle, addr_o equals the captured addr_i. Load takes priority over an advance on the same edge.
- R3: The beat count increments only on an edge where load_i is low, adv_n_i is low, and both strb_a_n_i and strb_b_n_i are high. If any of these fails, addr_o holds.
- R4: With order_i high (interleaved), addr_o[1:0] equals start[1:0] XOR count.
- R5: With order_i low (linear), addr_o[1:0] equals (start[1:0] + count) mod 4.
- R6: Bits addr_o[ADDR_W-1:2] change only on a load.
- R7: A fourth advance returns addr_o to the start address in either order.
- R8: order_i is applied to the live beat count. Changing order_i mid-burst remaps the current address without losing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a burst at addr_i |
| addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Active-low advance request |
| strb_a_n_i | input | 1 | Active-low address strobe A (blocks advance when low) |
| strb_b_n_i | input | 1 | Active-low address strobe B (blocks advance when low) |
| order_i | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_o | output | ADDR_W | Current array address |

## Verification
On every cycle, the assertions check four things:
- the captured address appears one cycle after a load;
- the upper bits never move between loads;
- a blocked advance leaves the address unchanged;
- each linear step adds one to the low bits, and each interleaved step flips one or two of them.

Some behaviour needs a known start point and a count of steps, so only the bench scenarios can show it. This covers the exact interleaved sequence from each start offset, the wrap back to the start after four beats, and the remap when the order pin changes mid-burst.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned BURST_LEN = 1 << BURST_W;
  typedef enum logic { ORD_LINEAR = 1'b0, ORD_INTERLEAVED = 1'b1 } order_e;
endpackage

// File: rtl/bag_start_reg.sv
module bag_start_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bag_beat_counter.sv
module bag_beat_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (step)   count <= count + 1'b1;
  end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             order,
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] beat_lo
);
  logic [CNT_W-1:0] ilv_lo;
  logic [CNT_W-1:0] lin_lo;

  genvar b;
  generate
    for (b = 0; b < CNT_W; b++) begin : g_xor
      assign ilv_lo[b] = start_lo[b] ^ count[b];
    end
  endgenerate

  assign lin_lo = start_lo + count;

  always_comb begin
    beat_lo = (order == bag_pkg::ORD_INTERLEAVED) ? ilv_lo : lin_lo;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_n_i,
  input  logic              strb_a_n_i,
  input  logic              strb_b_n_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W = bag_pkg::BURST_W;

  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  beat_lo;
  logic              step;

  assign step = !adv_n_i && strb_a_n_i && strb_b_n_i;

  bag_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n), .load(load_i), .d(addr_i), .q(start_q)
  );

  bag_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(load_i), .step(step), .count(count_q)
  );

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .order(order_i), .start_lo(start_q[CNT_W-1:0]), .count(count_q), .beat_lo(beat_lo)
  );

  assign addr_o = {start_q[ADDR_W-1:CNT_W], beat_lo};
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adv_n_i,
  input logic              strb_a_n_i,
  input logic              strb_b_n_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned LW = bag_pkg::BURST_W;

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(addr_i)));

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (addr_o[ADDR_W-1:LW] == $past(addr_o[ADDR_W-1:LW])));

  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (adv_n_i || !strb_a_n_i || !strb_b_n_i))
      |=> ((order_i != $past(order_i)) || $stable(addr_o)));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && strb_a_n_i && strb_b_n_i && !order_i)
      |=> (order_i || (addr_o[LW-1:0] == LW'($past(addr_o[LW-1:0]) + 1'b1))));

  p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && strb_a_n_i && strb_b_n_i && order_i)
      |=> (!order_i || ($countones(addr_o[LW-1:0] ^ $past(addr_o[LW-1:0])) inside {1, 2})));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_bag_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i), .adv_n_i(adv_n_i),
  .strb_a_n_i(strb_a_n_i), .strb_b_n_i(strb_b_n_i), .order_i(order_i), .addr_o(addr_o)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int unsigned AW = 18;

  typedef struct packed {
    logic [AW-1:0] start;
    logic          order;
    logic [2:0]    steps;
    logic [AW-1:0] expect_a;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{18'h2A5C6, 1'b1, 3'd1, 18'h2A5C7},
    '{18'h2A5C6, 1'b1, 3'd2, 18'h2A5C4},
    '{18'h2A5C6, 1'b1, 3'd3, 18'h2A5C5},
    '{18'h2A5C6, 1'b1, 3'd4, 18'h2A5C6},
    '{18'h1F3F9, 1'b0, 3'd1, 18'h1F3FA},
    '{18'h1F3F9, 1'b0, 3'd2, 18'h1F3FB},
    '{18'h1F3F9, 1'b0, 3'd3, 18'h1F3F8},
    '{18'h1F3F9, 1'b0, 3'd4, 18'h1F3F9},
    '{18'h3FFFD, 1'b1, 3'd1, 18'h3FFFC},
    '{18'h3FFFD, 1'b1, 3'd2, 18'h3FFFF},
    '{18'h3FFFD, 1'b1, 3'd3, 18'h3FFFE},
    '{18'h3FFFD, 1'b1, 3'd4, 18'h3FFFD},
    '{18'h3FFFF, 1'b1, 3'd2, 18'h3FFFD},
    '{18'h3FFFF, 1'b0, 3'd1, 18'h3FFFC}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adv_n_i = 1'b1;
  logic          strb_a_n_i = 1'b1;
  logic          strb_b_n_i = 1'b1;
  logic          order_i = 1'b1;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i), .adv_n_i(adv_n_i),
    .strb_a_n_i(strb_a_n_i), .strb_b_n_i(strb_b_n_i), .order_i(order_i), .addr_o(addr_o)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_v);
    checks++;
    if (addr_o !== exp_v) begin
      errors++;
      $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp_v);
    end
  endtask

  // Drive on the falling edge; after the next rising edge, wait to the next falling edge.
  task automatic cycle(input logic ld, input logic [AW-1:0] a, input logic adv_n,
                       input logic sa_n, input logic sb_n);
    load_i = ld; addr_i = a; adv_n_i = adv_n; strb_a_n_i = sa_n; strb_b_n_i = sb_n;
    @(negedge clk);
    load_i = 1'b0; adv_n_i = 1'b1; strb_a_n_i = 1'b1; strb_b_n_i = 1'b1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    for (int i = 0; i < NV; i++) begin
      order_i = VECS[i].order;
      cycle(1'b1, VECS[i].start, 1'b1, 1'b1, 1'b1);
      check("R2 load", VECS[i].start);
      for (int s = 0; s < int'(VECS[i].steps); s++) cycle(1'b0, '0, 1'b0, 1'b1, 1'b1);
      check(VECS[i].order ? "R4 R6 R7 interleaved" : "R5 R6 R7 linear", VECS[i].expect_a);
    end

    // R3 gating
    order_i = 1'b0;
    cycle(1'b1, 18'h00A51, 1'b1, 1'b1, 1'b1);
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R3 strobe A blocks", 18'h00A51);
    cycle(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R3 strobe B blocks", 18'h00A51);
    cycle(1'b0, '0, 1'b1, 1'b1, 1'b1);
    check("R3 advance idle", 18'h00A51);
    cycle(1'b0, '0, 1'b0, 1'b1, 1'b1);
    check("R3 qualified advance", 18'h00A52);

    // R2 load priority over advance
    cycle(1'b1, 18'h15557, 1'b0, 1'b1, 1'b1);
    check("R2 load beats advance", 18'h15557);

    // R8 order change mid-burst: start low 01, count 1
    cycle(1'b1, 18'h02001, 1'b1, 1'b1, 1'b1);
    cycle(1'b0, '0, 1'b0, 1'b1, 1'b1);
    check("R8 linear beat", 18'h02002);
    order_i = 1'b1;
    #1;
    check("R8 remapped interleaved", 18'h02000);
    cycle(1'b0, '0, 1'b0, 1'b1, 1'b1);
    check("R8 count kept", 18'h02003);

    // R1 reset mid-burst
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule